// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is a single memory-to-memory DMA channel. Software loads a source address, a destination address, a next-descriptor pointer, a control word and a configuration word through a small register port, then sets the enable bit. The channel moves the programmed number of data items. Each item is one read at the source width followed by one write at the destination width. When the count is used up and the next pointer is nonzero, the channel reads a four-word descriptor from memory and carries on with it. A next pointer of zero ends the chain.

Two sticky status flags report completion and failure. Terminal count is raised when a descriptor whose control word asks for it finishes. Error is raised for a bad width code or a misaligned next pointer. Software clears each flag by writing a one to its own clear register. An interrupt line combines the two flags under per-flag enables held in the configuration word.

The memory port is a plain request/grant port. A request completes in the cycle in which grant is high, and read data is valid in that same cycle. A side output marks the beat that ends each burst group.

Top module: `dma_llc_chan`

## Requirements
- R1: After reset every readable register reads 0, `mem_req` is low and `irq` is low.
- R2: With the channel enabled, the count in control bits [10:0] sets how many items are moved. Each item is one read at the source address (`mem_size` = source width code) and then one write of the read data, zero-extended beyond the source width, at the destination address (`mem_size` = destination width code). Width codes in control bits [20:18] (source) and [23:21] (destination) are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R3: Control bit 26 set advances the source address by the source width after each item, and control bit 27 does the same for the destination address. When a bit is clear, that address stays fixed.
- R4: A width code of 3 to 7 in either width field sets the error status (status bit 1) and clears the enable bit. No memory access is made.
- R5: Burst codes sit in control bits [14:12] (source) and [17:15] (destination). Code 0 means 1 beat, and code n > 0 means 2^(n+1) beats. `mem_last` is high on a read beat that ends a source burst group or that moves the last item. Likewise it is high on a write beat that ends a destination group or that moves the last item.
- R6: When a descriptor ends with a nonzero, 4-byte aligned next pointer P, the channel reads the words at P, P+4, P+8 and P+12 in that order. These become source, destination, next pointer and control, and the channel then runs that descriptor.
- R7: When a descriptor ends with a next pointer whose bits [1:0] are nonzero, the error status is set, the enable bit is cleared and no descriptor is fetched.
- R8: When a descriptor finishes, terminal-count status (status bit 0) is set if that descriptor's control bit 31 is 1, and is left unchanged otherwise.
- R9: When the final descriptor ends, configuration bit 0 (enable) clears. Configuration bit 17 reads 1 while the channel runs and 0 once it is idle.
- R10: While configuration bit 18 (halt) is 1, no new read is issued, a write already pending completes, and bit 17 reads 0. Clearing halt resumes the transfer without loss.
- R11: Status register 5 reads bit 0 = terminal count, bit 1 = error and bit 2 = their OR. Writing 1 to bit 0 of register 6 clears terminal count, and writing 1 to bit 0 of register 7 clears error. Writing 0 to either leaves the flag set.
- R12: `irq` = (terminal count AND configuration bit 15) OR (error AND configuration bit 14).
- R13: Control bits [30:28] are stored and read back but change no behaviour. At the end of a run the control register reads back its written value with bits [10:0] at 0.

Register word addresses on `reg_addr`: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration, 5 status, 6 terminal-count clear, 7 error clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data |
| mem_last | output | 1 | Beat ends a burst group |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| irq | output | 1 | Combined, enabled interrupt |

## Verification
On every cycle, assertions check the following. An idle channel never requests memory. Each completed write lowers the count by exactly one. A fixed source address does not move. The final item's beats carry the group-end mark. A descriptor fetch always starts from an aligned base. On the register side, they check that a clear write removes a flag, that a flag holds until it is cleared, and that the end of a chain drops the enable bit.

Only the bench scenarios can show the end-to-end outcome. That covers the moved data under each width and increment setting, the order of the four fetch addresses, group-end marks against random burst codes and random grant stalls, error outcomes with zero memory traffic, and the halt window, whose quiet bus and cleared active flag are observed over many cycles before the transfer resumes.

// File: rtl/dma_llc_pkg.sv
// Shared types and helper functions for the linked-list DMA channel.
// Assumes a 32-bit address and data path.
package dma_llc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_FETCH = 3'd4
    } eng_state_t;

    // Register word addresses
    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_NEXT = 3'd2;
    localparam logic [2:0] RA_CTRL = 3'd3;
    localparam logic [2:0] RA_CFG  = 3'd4;
    localparam logic [2:0] RA_STAT = 3'd5;
    localparam logic [2:0] RA_TCLR = 3'd6;
    localparam logic [2:0] RA_ECLR = 3'd7;

    // Beats in a burst group: code 0 -> 1, code n -> 2^(n+1)
    function automatic logic [8:0] burst_beats(input logic [2:0] code);
        return (code == 3'd0) ? 9'd1 : (9'd1 << ({1'b0, code} + 4'd1));
    endfunction

    // Byte-lane mask for a legal width code
    function automatic logic [31:0] width_mask(input logic [1:0] w);
        unique case (w)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_llc_burst_track.sv
// Counts beats inside a burst group and flags the beat that closes it.
// Assumes clr is pulsed before the first beat of each descriptor.
module dma_llc_burst_track #(
    parameter int CW = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       beat,
    input  logic [2:0] code,
    input  logic       last_xfer,
    output logic       grp_last
);
    import dma_llc_pkg::*;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] beats;

    // Group size from the burst code
    always_comb beats = CW'(burst_beats(code));

    // Group closes on its final beat or on the final item
    always_comb grp_last = (cnt_q == beats - CW'(1)) || last_xfer;

    // Beat counter within the current group
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (beat)      cnt_q <= grp_last ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/dma_llc_engine.sv
// Transfer engine: owns source, destination, next and control registers,
// runs item read/write pairs and fetches chained descriptors.
// Assumes a grant completes the access in the same cycle.
module dma_llc_engine #(
    parameter int CNT_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_we,
    input  logic [1:0]  sw_sel,
    input  logic [31:0] sw_data,
    input  logic        ch_en,
    input  logic        ch_halt,
    output logic [31:0] src_q,
    output logic [31:0] dst_q,
    output logic [31:0] nxt_q,
    output logic [31:0] ctrl_q,
    output logic        active,
    output logic        tc_evt,
    output logic        err_evt,
    output logic        stop_evt,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    output logic        mem_last,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata
);
    import dma_llc_pkg::*;

    localparam int NTRK = 2;

    eng_state_t       state;
    logic [1:0]       fidx;
    logic [31:0]      fbase;
    logic [31:0]      dbuf;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       sw_code, dw_code;
    logic             width_ok, last_xfer, desc_end, go_fetch;
    logic             rd_fire, wr_fire, fetch_fire;
    logic             trk_beat [NTRK];
    logic [2:0]       trk_code [NTRK];
    logic             trk_last [NTRK];

    // Control field decode
    always_comb begin
        cnt       = ctrl_q[CNT_W-1:0];
        sw_code   = ctrl_q[20:18];
        dw_code   = ctrl_q[23:21];
        width_ok  = (sw_code <= 3'd2) && (dw_code <= 3'd2);
        last_xfer = (cnt == CNT_W'(1));
        go_fetch  = (nxt_q != 32'd0) && (nxt_q[1:0] == 2'b00);
    end

    // Memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'd0;
        mem_size  = 2'd0;
        mem_wdata = dbuf;
        mem_last  = 1'b0;
        unique case (state)
            ST_RD: begin
                mem_req  = !ch_halt;
                mem_addr = src_q;
                mem_size = sw_code[1:0];
                mem_last = trk_last[0];
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                mem_size = dw_code[1:0];
                mem_last = trk_last[1];
            end
            ST_FETCH: begin
                mem_req  = !ch_halt;
                mem_addr = fbase + {28'd0, fidx, 2'b00};
                mem_size = 2'd2;
                mem_last = (fidx == 2'd3);
            end
            default: ;
        endcase
    end

    // Handshake and descriptor-end events
    always_comb begin
        rd_fire    = (state == ST_RD)    && mem_req && mem_gnt;
        wr_fire    = (state == ST_WR)    && mem_gnt;
        fetch_fire = (state == ST_FETCH) && mem_req && mem_gnt;
        desc_end   = (wr_fire && last_xfer) ||
                     ((state == ST_CHECK) && width_ok && (cnt == '0));
        tc_evt     = desc_end && ctrl_q[31];
        err_evt    = ((state == ST_CHECK) && !width_ok) ||
                     (desc_end && (nxt_q != 32'd0) && (nxt_q[1:0] != 2'b00));
        stop_evt   = err_evt || (desc_end && (nxt_q == 32'd0));
        active     = (state != ST_IDLE) &&
                     !(ch_halt && (state == ST_RD || state == ST_FETCH));
    end

    // Source and destination burst-group trackers
    assign trk_beat[0] = rd_fire;
    assign trk_beat[1] = wr_fire;
    assign trk_code[0] = ctrl_q[14:12];
    assign trk_code[1] = ctrl_q[17:15];

    for (genvar g = 0; g < NTRK; g++) begin : g_trk
        dma_llc_burst_track #(.CW(9)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (state == ST_CHECK),
            .beat      (trk_beat[g]),
            .code      (trk_code[g]),
            .last_xfer (last_xfer),
            .grp_last  (trk_last[g])
        );
    end

    // Sequencer state, working registers and descriptor loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            nxt_q  <= '0;
            ctrl_q <= '0;
            fbase  <= '0;
            fidx   <= '0;
            dbuf   <= '0;
        end else begin
            if (sw_we) begin
                unique case (sw_sel)
                    2'd0:    src_q  <= sw_data;
                    2'd1:    dst_q  <= sw_data;
                    2'd2:    nxt_q  <= sw_data;
                    default: ctrl_q <= sw_data;
                endcase
            end
            unique case (state)
                ST_IDLE:  if (ch_en) state <= ST_CHECK;
                ST_CHECK: begin
                    if (!width_ok)       state <= ST_IDLE;
                    else if (cnt != '0)  state <= ST_RD;
                end
                ST_RD: if (rd_fire) begin
                    dbuf  <= mem_rdata & width_mask(sw_code[1:0]);
                    state <= ST_WR;
                end
                ST_WR: if (wr_fire) begin
                    if (ctrl_q[26]) src_q <= src_q + (32'd1 << sw_code[1:0]);
                    if (ctrl_q[27]) dst_q <= dst_q + (32'd1 << dw_code[1:0]);
                    ctrl_q[CNT_W-1:0] <= cnt - CNT_W'(1);
                    state <= ST_RD;
                end
                ST_FETCH: if (fetch_fire) begin
                    unique case (fidx)
                        2'd0:    src_q  <= mem_rdata;
                        2'd1:    dst_q  <= mem_rdata;
                        2'd2:    nxt_q  <= mem_rdata;
                        default: ctrl_q <= mem_rdata;
                    endcase
                    fidx <= fidx + 2'd1;
                    if (fidx == 2'd3) state <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
            if (desc_end) begin
                if (go_fetch) begin
                    state <= ST_FETCH;
                    fbase <= nxt_q;
                    fidx  <= 2'd0;
                end else begin
                    state <= ST_IDLE;
                end
            end
        end
    end

    // R1: an idle channel leaves the memory port quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req);

    // R2: every accepted write consumes exactly one item
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !sw_we) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R3: a non-incrementing source stays put across a write
    p_fixed_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !ctrl_q[26] && !sw_we) |=> $stable(src_q));

    // R5: the final item's write always closes a burst group
    p_last_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && last_xfer) |-> mem_last);

    // R7: descriptor fetches start only from aligned bases
    p_fetch_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (fbase[1:0] == 2'b00));

    // R10: after a write under halt, no read goes out while halt stays set
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_halt && wr_fire) |=> (!ch_halt || !(mem_req && !mem_we)));
endmodule

// File: rtl/dma_llc_regs.sv
// Configuration, status and register read path of the DMA channel.
// Assumes engine events are single-cycle pulses; a set event wins over a clear.
module dma_llc_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] src_q,
    input  logic [31:0] dst_q,
    input  logic [31:0] nxt_q,
    input  logic [31:0] ctrl_q,
    input  logic        active,
    input  logic        tc_evt,
    input  logic        err_evt,
    input  logic        stop_evt,
    output logic        sw_we,
    output logic [1:0]  sw_sel,
    output logic        ch_en,
    output logic        ch_halt,
    output logic        irq
);
    import dma_llc_pkg::*;

    logic [31:0] cfg_q;
    logic        tc_st, err_st;
    logic        cfg_wr, tc_clr, err_clr;

    // Write decode
    always_comb begin
        cfg_wr  = reg_we && (reg_addr == RA_CFG);
        tc_clr  = reg_we && (reg_addr == RA_TCLR) && reg_wdata[0];
        err_clr = reg_we && (reg_addr == RA_ECLR) && reg_wdata[0];
        sw_we   = reg_we && !reg_addr[2];
        sw_sel  = reg_addr[1:0];
        ch_en   = cfg_q[0];
        ch_halt = cfg_q[18];
        irq     = (tc_st && cfg_q[15]) || (err_st && cfg_q[14]);
    end

    // Configuration word; the engine drops enable at the end of a chain
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q    <= '0;
        else if (cfg_wr)   cfg_q    <= reg_wdata;
        else if (stop_evt) cfg_q[0] <= 1'b0;
    end

    // Sticky status flags with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_st  <= 1'b0;
            err_st <= 1'b0;
        end else begin
            tc_st  <= (tc_st  && !tc_clr)  || tc_evt;
            err_st <= (err_st && !err_clr) || err_evt;
        end
    end

    // Read mux
    always_comb begin
        unique case (reg_addr)
            RA_SRC:  reg_rdata = src_q;
            RA_DST:  reg_rdata = dst_q;
            RA_NEXT: reg_rdata = nxt_q;
            RA_CTRL: reg_rdata = ctrl_q;
            RA_CFG:  reg_rdata = {cfg_q[31:18], active, cfg_q[16:0]};
            RA_STAT: reg_rdata = {29'd0, tc_st || err_st, err_st, tc_st};
            default: reg_rdata = 32'd0;
        endcase
    end

    // R11: a clear write removes terminal count unless a new one arrives
    p_tc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && !tc_evt) |=> !tc_st);

    // R11: error stays set until software clears it
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_st && !err_clr) |=> err_st);

    // R9: chain end or error drops enable unless software rewrites it
    p_stop_drops_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !cfg_wr) |=> !ch_en);
endmodule

// File: rtl/dma_llc_chan.sv
// Top of the linked-list DMA channel: register block plus transfer engine.
// Assumes a single clock domain and a same-cycle grant memory port.
module dma_llc_chan #(
    parameter int CNT_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    output logic        mem_last,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    logic [31:0] src_q, dst_q, nxt_q, ctrl_q;
    logic        active, tc_evt, err_evt, stop_evt;
    logic        sw_we, ch_en, ch_halt;
    logic [1:0]  sw_sel;

    dma_llc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q), .ctrl_q(ctrl_q),
        .active(active), .tc_evt(tc_evt), .err_evt(err_evt),
        .stop_evt(stop_evt), .sw_we(sw_we), .sw_sel(sw_sel),
        .ch_en(ch_en), .ch_halt(ch_halt), .irq(irq)
    );

    dma_llc_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(reg_wdata),
        .ch_en(ch_en), .ch_halt(ch_halt),
        .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q), .ctrl_q(ctrl_q),
        .active(active), .tc_evt(tc_evt), .err_evt(err_evt),
        .stop_evt(stop_evt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_last(mem_last),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/tb_dma_llc_chan.sv
module tb_dma_llc_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_last, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_gnt = 1'b0;

    always #2 clk = ~clk;

    dma_llc_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_last(mem_last), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    logic [7:0] mem   [0:2047];
    logic [7:0] ref_m [0:2047];
    int total = 0, bad = 0;
    bit stall = 1'b0, finished = 1'b0;
    bit mon_on = 1'b0, halt_watch = 1'b0;
    int rd_i, wr_i, exp_n, exp_sb, exp_db, mon_bad, acc_cnt = 0, fcnt = 0, halt_viol = 0;
    logic [1:0] exp_sw, exp_dw;
    logic [31:0] flog [4];

    // memory read path
    always_comb begin
        logic [10:0] a;
        a = mem_addr[10:0];
        mem_rdata = {mem[a + 11'd3], mem[a + 11'd2], mem[a + 11'd1], mem[a]};
    end

    // grant generation away from the active edge
    always @(negedge clk) mem_gnt <= stall ? ($urandom_range(0, 3) != 0) : 1'b1;

    // memory model and beat monitor
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            acc_cnt++;
            if (mem_we)
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[mem_addr[10:0] + 11'(b)] <= mem_wdata[8*b +: 8];
            if (mon_on) begin
                if (!mem_we) begin
                    if (mem_size != exp_sw ||
                        mem_last != ((rd_i % exp_sb) == exp_sb - 1 || rd_i == exp_n - 1))
                        mon_bad++;
                    rd_i++;
                end else begin
                    if (mem_size != exp_dw ||
                        mem_last != ((wr_i % exp_db) == exp_db - 1 || wr_i == exp_n - 1))
                        mon_bad++;
                    wr_i++;
                end
            end
            if (!mem_we && mem_addr >= 32'h700 && fcnt < 4) begin
                flog[fcnt] = mem_addr;
                fcnt++;
            end
        end
    end

    always @(negedge clk) if (halt_watch && mem_req && !mem_we) halt_viol++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int k = 0; k < 3000; k++) begin
            reg_read(3'd4, c);
            if (!c[0]) break;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit tc, input logic [2:0] attr, input bit di, input bit si,
                                            input logic [2:0] dw, input logic [2:0] sw,
                                            input logic [2:0] dbc, input logic [2:0] sbc, input int n);
        return {tc, attr, di, si, 2'b00, dw, sw, dbc, sbc, 1'b0, 11'(n)};
    endfunction

    // expected effect of one descriptor on the reference image
    task automatic apply_ref(input int sa, input int da, input int sw, input int dw, input int n, input bit si, input bit di);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            int s, d;
            s = sa + (si ? i * (1 << sw) : 0);
            d = da + (di ? i * (1 << dw) : 0);
            v = 0;
            for (int b = 0; b < (1 << sw); b++) v[8*b +: 8] = mem[(s + b) % 2048];
            for (int b = 0; b < (1 << dw); b++) ref_m[(d + b) % 2048] = v[8*b +: 8];
        end
    endtask

    function automatic int mism();
        int m = 0;
        for (int i = 0; i < 2048; i++) if (mem[i] !== ref_m[i]) m++;
        return m;
    endfunction

    task automatic snap();
        for (int i = 0; i < 2048; i++) ref_m[i] = mem[i];
    endtask

    task automatic run_one(input int sw, input int dw, input int n, input bit si, input bit di,
                           input int sbc, input int dbc, input bit tcb, input logic [2:0] attr);
        logic [31:0] c, ctl;
        snap();
        apply_ref(32'h100, 32'h400, sw, dw, n, si, di);
        ctl = mk_ctrl(tcb, attr, di, si, 3'(dw), 3'(sw), 3'(dbc), 3'(sbc), n);
        exp_sw = 2'(sw); exp_dw = 2'(dw); exp_n = n;
        exp_sb = 1 << (sbc == 0 ? 0 : sbc + 1);
        exp_db = 1 << (dbc == 0 ? 0 : dbc + 1);
        rd_i = 0; wr_i = 0; mon_bad = 0; mon_on = 1'b1;
        reg_write(3'd0, 32'h100);
        reg_write(3'd1, 32'h400);
        reg_write(3'd2, 32'h0);
        reg_write(3'd3, ctl);
        reg_write(3'd4, 32'h0000_C001);
        wait_idle();
        mon_on = 1'b0;
        check(mism() == 0, "R2/R3 data moved", mism(), 0);
        check(mon_bad == 0 && wr_i == n, "R5/R2 beat sizes and group marks", mon_bad, 0);
        reg_read(3'd5, c);
        check(c[0] == tcb, "R8 terminal count per control bit 31", c[0], tcb);
        check(irq == tcb, "R12 irq from enabled terminal count", irq, tcb);
        reg_read(3'd4, c);
        check(c[0] == 1'b0 && c[17] == 1'b0, "R9 enable and active clear at end", c, 0);
        reg_read(3'd3, c);
        check(c == (ctl & ~32'h7FF), "R13 control readback with attributes", c, ctl & ~32'h7FF);
        reg_write(3'd6, 32'h1);
        reg_read(3'd5, c);
        check(c == 0, "R11 terminal count cleared", c, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        int a0;
        void'($urandom(32'd7711));
        for (int i = 0; i < 2048; i++) mem[i] = 8'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int r = 0; r < 8; r++) begin
            reg_read(3'(r), c);
            check(c == 0, "R1 register zero after reset", c, 0);
        end
        check(!mem_req && !irq, "R1 port quiet after reset", {mem_req, irq}, 0);

        // directed corner runs
        run_one(2, 2, 16, 1, 1, 7, 1, 1, 3'b101);
        run_one(0, 2, 5, 1, 1, 2, 0, 1, 3'b000);
        run_one(1, 0, 9, 0, 1, 0, 3, 0, 3'b010);
        run_one(2, 1, 6, 1, 0, 1, 2, 1, 3'b111);
        run_one(0, 0, 1, 1, 1, 3, 3, 1, 3'b000);

        // constrained random runs with grant stalls
        stall = 1'b1;
        for (int k = 0; k < 10; k++)
            run_one($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(1, 20),
                    1'($urandom), 1'($urandom), $urandom_range(0, 7), $urandom_range(0, 7),
                    1'($urandom), 3'($urandom));
        stall = 1'b0;

        // R4 invalid width codes
        for (int v = 0; v < 2; v++) begin
            a0 = acc_cnt;
            reg_write(3'd3, v == 0 ? mk_ctrl(1, 0, 1, 1, 3'd0, 3'd3, 0, 0, 4)
                                   : mk_ctrl(1, 0, 1, 1, 3'd5, 3'd2, 0, 0, 4));
            reg_write(3'd2, 32'h0);
            reg_write(3'd4, 32'h0000_4001);
            wait_idle();
            reg_read(3'd5, c);
            check(c == 32'h6, "R4 error status from bad width", c, 32'h6);
            check(acc_cnt == a0, "R4 no memory access", acc_cnt, a0);
            check(irq == 1'b1, "R12 irq from enabled error", irq, 1);
            reg_write(3'd7, 32'h0);
            reg_read(3'd5, c);
            check(c == 32'h6, "R11 zero write keeps error", c, 32'h6);
            reg_write(3'd7, 32'h1);
            reg_read(3'd5, c);
            check(c == 0 && !irq, "R11 error cleared", c, 0);
        end

        // R6 chained descriptor
        snap();
        apply_ref(32'h100, 32'h400, 2, 2, 3, 1, 1);
        apply_ref(32'h180, 32'h480, 2, 2, 4, 1, 1);
        begin
            logic [31:0] dw4 [4];
            dw4[0] = 32'h180; dw4[1] = 32'h480; dw4[2] = 32'h0;
            dw4[3] = mk_ctrl(1, 0, 1, 1, 3'd2, 3'd2, 0, 0, 4);
            for (int w = 0; w < 4; w++)
                for (int b = 0; b < 4; b++) begin
                    mem[32'h700 + 4*w + b] = dw4[w][8*b +: 8];
                    ref_m[32'h700 + 4*w + b] = dw4[w][8*b +: 8];
                end
        end
        fcnt = 0;
        reg_write(3'd0, 32'h100);
        reg_write(3'd1, 32'h400);
        reg_write(3'd2, 32'h700);
        reg_write(3'd3, mk_ctrl(0, 0, 1, 1, 3'd2, 3'd2, 0, 0, 3));
        reg_write(3'd4, 32'h0000_8001);
        wait_idle();
        check(mism() == 0, "R6 chained data", mism(), 0);
        check(fcnt == 4 && flog[0] == 32'h700 && flog[1] == 32'h704 &&
              flog[2] == 32'h708 && flog[3] == 32'h70C, "R6 fetch order", flog[3], 32'h70C);
        reg_read(3'd5, c);
        check(c == 32'h5, "R8 tc from final descriptor", c, 32'h5);
        reg_read(3'd2, c);
        check(c == 0, "R6 next pointer loaded from descriptor", c, 0);
        reg_write(3'd6, 32'h1);

        // R7 misaligned next pointer
        a0 = acc_cnt;
        fcnt = 0;
        reg_write(3'd0, 32'h100);
        reg_write(3'd1, 32'h400);
        reg_write(3'd2, 32'h702);
        reg_write(3'd3, mk_ctrl(0, 0, 1, 1, 3'd0, 3'd0, 0, 0, 1));
        reg_write(3'd4, 32'h0000_0001);
        wait_idle();
        reg_read(3'd5, c);
        check(c == 32'h6, "R7 misaligned pointer error", c, 32'h6);
        check(acc_cnt == a0 + 2 && fcnt == 0, "R7 no fetch after item", acc_cnt - a0, 2);
        reg_read(3'd4, c);
        check(c[0] == 1'b0, "R7 enable cleared", c, 0);
        reg_write(3'd7, 32'h1);

        // R10 halt and resume
        snap();
        apply_ref(32'h100, 32'h400, 0, 0, 200, 1, 1);
        reg_write(3'd0, 32'h100);
        reg_write(3'd1, 32'h400);
        reg_write(3'd2, 32'h0);
        reg_write(3'd3, mk_ctrl(0, 0, 1, 1, 3'd0, 3'd0, 0, 0, 200));
        reg_write(3'd4, 32'h0000_0001);
        repeat (20) @(negedge clk);
        reg_write(3'd4, 32'h0004_0001);
        repeat (3) @(negedge clk);
        halt_watch = 1'b1;
        a0 = acc_cnt;
        reg_read(3'd4, c);
        check(c[17] == 1'b0 && c[0] == 1'b1, "R10 halted channel not active", c, 32'h0004_0001);
        repeat (20) @(negedge clk);
        halt_watch = 1'b0;
        check(halt_viol == 0 && acc_cnt == a0, "R10 no reads under halt", halt_viol, 0);
        reg_read(3'd3, c);
        check(c[10:0] != 0 && c[10:0] < 200, "R10 transfer paused midway", c[10:0], 100);
        reg_write(3'd4, 32'h0000_0001);
        reg_read(3'd4, c);
        check(c[17] == 1'b1, "R9 active while running", c, 32'h0002_0001);
        wait_idle();
        check(mism() == 0, "R10 data complete after resume", mism(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule